// File: doc/BRIEF.md
# Dual-Match Pulse Timer

This block is a pulse-width-modulated timer built around one up-counter and two compare values. The counter advances only on cycles where an external prescaler tick is present, and only while the run-enable bit is set. When the count reaches the rising-edge compare value, the waveform goes high. When the count reaches the falling-edge compare value, the waveform goes low. The falling-edge value therefore sets the end of each cycle, and the rising-edge value sets where the high phase begins inside that cycle.

A start strobe clears the counter and launches the timer. In continuous mode, the counter returns to zero after the falling match, so the waveform repeats every falling-value-plus-one ticks. In single-shot mode, the counter halts at the falling match and the output stays low until the next start. Each compare match can set its own sticky interrupt flag, and each flag has its own enable. The flags are cleared by writing ones to a clear address. An output-enable bit gates the waveform onto the output pin, and the counter keeps running internally while the output is gated off.

Top module: `pwm_rf_timer`

## Requirements
- R1: After reset, `pwm_o`, `oe_o` and `irq_o` are all low, and the timer stays idle until a start strobe arrives.
- R2: A counted tick at which the count equals the rise value (address 0) drives the waveform high from the next cycle, unless the count also equals the fall value.
- R3: A counted tick at which the count equals the fall value (address 1) drives the waveform low from the next cycle.
- R4: In continuous mode (control bit 1 = 1), the counter returns to zero after the fall match. The waveform then repeats with a period of fall+1 ticks and is high for the count values from rise up to fall-1.
- R5: In single-shot mode (control bit 1 = 0), the counter halts at the fall match. The waveform then stays low, and no further match occurs, until the next start strobe.
- R6: The counter advances by one only on a cycle with `tick` high and the run bit (control bit 0) set. A start strobe takes priority over the tick, sets the count to zero and leaves the waveform low.
- R7: A rise match sets a sticky rise flag if control bit 3 is set, and a fall match sets a sticky fall flag if control bit 4 is set. `irq_o` is the OR of the two flags and stays high until a clear.
- R8: A write to address 3 clears the rise flag where data bit 0 is one and the fall flag where data bit 1 is one. A flag whose clear bit is zero is left as it was.
- R9: `oe_o` follows control bit 2, and `pwm_o` is low while that bit is zero. Counting continues while the output is gated, so re-enabling the output shows the waveform at its current phase.
- R10: When the rise and fall values are equal, the fall match wins and the waveform never goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 rise, 1 fall, 2 control, 3 flag clear |
| wr_data | input | W | Write data |
| start | input | 1 | Clears the counter and starts the timer |
| tick | input | 1 | Prescaled count enable |
| pwm_o | output | 1 | Gated waveform output |
| oe_o | output | 1 | Output-enable signal for the pad |
| irq_o | output | 1 | Interrupt, OR of the sticky match flags |

## Verification
The hardest case to reach is a waveform whose phase has to be predicted after many irregular ticks. This matters most when output gating, pauses of the run bit, or a halted single shot hide the counter from the ports. The stimulus drives the tick with a random density and counts every accepted tick in the bench, so a model of the requirements predicts the level on every cycle. Directed sequences gate the output off and pause the counter mid-cycle. They then confirm that the waveform reappears at exactly the phase the accepted tick count predicts.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_RISE = 2'd0,
      REG_FALL = 2'd1,
      REG_CTRL = 2'd2,
      REG_CLR  = 2'd3
   } reg_addr_e;

   // control field positions
   localparam int CTL_RUN     = 0;
   localparam int CTL_CONT    = 1;
   localparam int CTL_OE      = 2;
   localparam int CTL_IE_RISE = 3;
   localparam int CTL_IE_FALL = 4;
   localparam int CTL_W       = 5;

   // interrupt sources
   localparam int SRC_RISE = 0;
   localparam int SRC_FALL = 1;
   localparam int N_SRC    = 2;
endpackage

// File: rtl/pwm_rf_regs.sv
module pwm_rf_regs
   import pwm_rf_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic [N_SRC-1:0]  hit,
   output logic [W-1:0]      rise_val,
   output logic [W-1:0]      fall_val,
   output logic              run_en,
   output logic              cont_mode,
   output logic              oe,
   output logic              irq
);
   logic [CTL_W-1:0] ctrl_q;
   logic [N_SRC-1:0] ie;
   logic [N_SRC-1:0] flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_val <= '0;
         fall_val <= '0;
         ctrl_q   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_RISE: rise_val <= wr_data;
            REG_FALL: fall_val <= wr_data;
            REG_CTRL: ctrl_q   <= wr_data[CTL_W-1:0];
            default:  ;
         endcase
      end
   end

   assign run_en          = ctrl_q[CTL_RUN];
   assign cont_mode       = ctrl_q[CTL_CONT];
   assign oe              = ctrl_q[CTL_OE];
   assign ie[SRC_RISE]    = ctrl_q[CTL_IE_RISE];
   assign ie[SRC_FALL]    = ctrl_q[CTL_IE_FALL];

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (hit[s] && ie[s])
            flag_q <= 1'b1;
         else if (wr_en && wr_addr == REG_CLR && wr_data[s])
            flag_q <= 1'b0;
      end
      assign flags[s] = flag_q;
   end

   assign irq = |flags;
endmodule

// File: rtl/pwm_rf_counter.sv
module pwm_rf_counter
   import pwm_rf_pkg::*;
#(
   parameter int W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             run_en,
   input  logic             cont_mode,
   input  logic [W-1:0]     rise_val,
   input  logic [W-1:0]     fall_val,
   output logic [W-1:0]     cnt,
   output logic             running,
   output logic [N_SRC-1:0] hit
);
   localparam logic [W-1:0] CNT_ONE = W'(1);

   logic step;

   assign step           = running && run_en && tick && !start;
   assign hit[SRC_RISE]  = step && (cnt == rise_val);
   assign hit[SRC_FALL]  = step && (cnt == fall_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (step) begin
         if (hit[SRC_FALL]) begin
            if (cont_mode)
               cnt <= '0;
            else
               running <= 1'b0;
         end else begin
            cnt <= cnt + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/pwm_rf_out.sv
module pwm_rf_out
   import pwm_rf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [N_SRC-1:0] hit,
   input  logic             oe,
   output logic             raw,
   output logic             pwm
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         raw <= 1'b0;
      else if (start || hit[SRC_FALL])
         raw <= 1'b0;
      else if (hit[SRC_RISE])
         raw <= 1'b1;
   end

   assign pwm = raw && oe;
endmodule

// File: rtl/pwm_rf_timer.sv
module pwm_rf_timer
   import pwm_rf_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              start,
   input  logic              tick,
   output logic              pwm_o,
   output logic              oe_o,
   output logic              irq_o
);
   if (W < CTL_W) begin : g_chk_w
      $error("pwm_rf_timer: W must be at least %0d", CTL_W);
   end

   logic [W-1:0]     rise_val;
   logic [W-1:0]     fall_val;
   logic             run_en;
   logic             cont_mode;
   logic             oe;
   logic [W-1:0]     cnt;
   logic             running;
   logic [N_SRC-1:0] hit;
   logic             raw;

   pwm_rf_regs #(.W(W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .hit      (hit),
      .rise_val (rise_val),
      .fall_val (fall_val),
      .run_en   (run_en),
      .cont_mode(cont_mode),
      .oe       (oe),
      .irq      (irq_o)
   );

   pwm_rf_counter #(.W(W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tick     (tick),
      .run_en   (run_en),
      .cont_mode(cont_mode),
      .rise_val (rise_val),
      .fall_val (fall_val),
      .cnt      (cnt),
      .running  (running),
      .hit      (hit)
   );

   pwm_rf_out out_i (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .hit  (hit),
      .oe   (oe),
      .raw  (raw),
      .pwm  (pwm_o)
   );

   assign oe_o = oe;
endmodule

// File: rtl/pwm_rf_timer_chk.sv
module pwm_rf_timer_chk
   import pwm_rf_pkg::*;
#(
   parameter int W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              start,
   input logic              tick,
   input logic              run_en,
   input logic [W-1:0]      cnt,
   input logic [W-1:0]      rise_val,
   input logic [W-1:0]      fall_val,
   input logic              running,
   input logic              raw,
   input logic              oe_o,
   input logic              pwm_o,
   input logic              irq_o
);
   logic counted;
   assign counted = running && run_en && tick && !start;

   // R2
   a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      counted && cnt == rise_val && cnt != fall_val |=> raw);

   // R3
   a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      counted && cnt == fall_val |=> !raw);

   // R5
   a_r5_halt_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> !raw);

   // R6
   a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && run_en) && !start |=> $stable(cnt));

   // R6
   a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == '0) && running && !raw);

   // R7
   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !(wr_en && wr_addr == REG_CLR) |=> irq_o);

   // R9
   a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_o |-> !pwm_o);
endmodule

bind pwm_rf_timer pwm_rf_timer_chk #(.W(W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .start   (start),
   .tick    (tick),
   .run_en  (run_en),
   .cnt     (cnt),
   .rise_val(rise_val),
   .fall_val(fall_val),
   .running (running),
   .raw     (raw),
   .oe_o    (oe_o),
   .pwm_o   (pwm_o),
   .irq_o   (irq_o)
);

// File: tb/pwm_rf_timer_tb_top.sv
module pwm_rf_timer_tb_top;
   localparam int W = 16;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         start = 1'b0;
   logic         tick = 1'b0;
   logic         pwm_o, oe_o, irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench model state
   int  m_rise, m_fall, m_n;
   bit  m_cont, m_run, m_oe, m_ier, m_ief, m_fr, m_ff;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_rf_timer #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .tick(tick),
      .pwm_o(pwm_o), .oe_o(oe_o), .irq_o(irq_o)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // index of the count value handled by the n-th accepted tick, -1 if none
   function automatic int proc_cnt(int n);
      if (n == 0) return -1;
      if (m_cont) return (n - 1) % (m_fall + 1);
      if (n - 1 <= m_fall) return n - 1;
      return -1;
   endfunction

   function automatic bit exp_raw(int n);
      int c;
      if (n == 0) return 1'b0;
      c = m_cont ? (n - 1) % (m_fall + 1) : ((n - 1 < m_fall) ? n - 1 : m_fall);
      return (m_rise < m_fall) && (c >= m_rise) && (c < m_fall);
   endfunction

   task automatic cyc();
      @(posedge clk);
      #1;
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, int d);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d); tick = 1'b0;
      cyc();
      wr_en = 1'b0;
      if (a == 2'd3) begin
         if (d[0]) m_fr = 0;
         if (d[1]) m_ff = 0;
      end
   endtask

   task automatic set_ctrl(bit run, bit cont, bit oe, bit ier, bit ief);
      m_run = run; m_cont = cont; m_oe = oe; m_ier = ier; m_ief = ief;
      wr(2'd2, {27'd0, ief, ier, oe, cont, run});
   endtask

   task automatic do_start();
      start = 1'b1; tick = 1'b0;
      cyc();
      start = 1'b0;
      m_n = 0;
   endtask

   task automatic check_out(string req);
      chk({req, " pwm_o"}, pwm_o, exp_raw(m_n) && m_oe);
      chk({req, " irq_o"}, irq_o, m_fr || m_ff);
   endtask

   // one cycle with the given tick value; the model updates only on accepted ticks
   task automatic step(bit t, string req);
      int c;
      tick = t;
      cyc();
      tick = 1'b0;
      if (t && m_run) begin
         c = proc_cnt(m_n + 1);
         if (c >= 0) begin
            m_n++;
            if (c == m_rise && m_ier) m_fr = 1;
            if (c == m_fall && m_ief) m_ff = 1;
         end
      end
      check_out(req);
   endtask

   task automatic setup(int r, int f, bit cont, bit oe, bit ier, bit ief);
      m_rise = r; m_fall = f;
      wr(2'd0, r);
      wr(2'd1, f);
      set_ctrl(1'b1, cont, oe, ier, ief);
      wr(2'd3, 3);
      do_start();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = $urandom(32'h5EED_0042);
      m_rise = 0; m_fall = 0; m_n = 0;
      m_cont = 0; m_run = 0; m_oe = 0; m_ier = 0; m_ief = 0; m_fr = 0; m_ff = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, ticks before any start do nothing
      chk("R1 pwm_o", pwm_o, 0);
      chk("R1 oe_o", oe_o, 0);
      chk("R1 irq_o", irq_o, 0);
      m_oe = 1;
      wr(2'd0, 0); wr(2'd1, 5);
      m_rise = 0; m_fall = 5;
      wr(2'd2, 32'h1D);  // run, oe, both enables, single
      m_run = 1; m_ier = 1; m_ief = 1;
      tick = 1'b1; repeat (4) cyc(); tick = 1'b0;
      chk("R1 idle pwm_o", pwm_o, 0);
      chk("R1 idle irq_o", irq_o, 0);

      // R2 R3 R4: continuous, dense ticks
      setup(3, 8, 1, 1, 0, 0);
      for (int i = 0; i < 30; i++) step(1'b1, "R4");
      chk("R2 R3 oe_o", oe_o, 1);

      // R5: single shot halts low and stays low
      setup(2, 5, 0, 1, 1, 1);
      for (int i = 0; i < 15; i++) step(1'b1, "R5");
      chk("R5 halted pwm_o", pwm_o, 0);
      do_start();
      check_out("R5 restart");
      for (int i = 0; i < 4; i++) step(1'b1, "R5 retrig");
      chk("R5 retrig high", pwm_o, 1);

      // R10: equal compare values keep the waveform low
      setup(4, 4, 1, 1, 0, 0);
      for (int i = 0; i < 20; i++) step(1'b1, "R10");

      // R6: sparse ticks, pause via run bit, start overrides tick
      setup(2, 10, 1, 1, 0, 0);
      for (int i = 0; i < 3; i++) step(1'b1, "R6");
      step(1'b0, "R6 no tick");
      set_ctrl(1'b0, 1, 1, 0, 0);
      for (int i = 0; i < 5; i++) step(1'b1, "R6 paused");
      chk("R6 paused high", pwm_o, 1);
      set_ctrl(1'b1, 1, 1, 0, 0);
      for (int i = 0; i < 12; i++) step(1'b1, "R6 resumed");
      start = 1'b1; tick = 1'b1;
      cyc();
      start = 1'b0; tick = 1'b0; m_n = 0;
      check_out("R6 start with tick");
      for (int i = 0; i < 3; i++) step(1'b1, "R6 after start");
      chk("R6 third tick high", pwm_o, 1);

      // R9: gated output while counting continues
      setup(3, 9, 1, 1, 0, 0);
      for (int i = 0; i < 2; i++) step(1'b1, "R9");
      set_ctrl(1'b1, 1, 0, 0, 0);
      chk("R9 oe_o low", oe_o, 0);
      for (int i = 0; i < 4; i++) step(1'b1, "R9 gated");
      set_ctrl(1'b1, 1, 1, 0, 0);
      chk("R9 oe_o high", oe_o, 1);
      chk("R9 phase kept", pwm_o, 1);
      for (int i = 0; i < 10; i++) step(1'b1, "R9 regated");

      // R7 R8: per-source enables, sticky flag, write-one-to-clear
      setup(2, 6, 0, 1, 1, 0);
      for (int i = 0; i < 4; i++) step(1'b1, "R7 rise only");
      chk("R7 rise flag", irq_o, 1);
      for (int i = 0; i < 6; i++) step(1'b0, "R7 sticky");
      wr(2'd3, 2);
      chk("R8 wrong bit keeps", irq_o, 1);
      wr(2'd3, 1);
      chk("R8 cleared", irq_o, 0);
      for (int i = 0; i < 6; i++) step(1'b1, "R7 fall disabled");
      chk("R7 fall disabled", irq_o, 0);
      setup(2, 6, 1, 1, 0, 1);
      for (int i = 0; i < 6; i++) step(1'b1, "R7 before fall");
      chk("R7 no fall yet", irq_o, 0);
      step(1'b1, "R7 fall");
      chk("R7 fall flag", irq_o, 1);
      wr(2'd3, 2);
      chk("R8 fall cleared", irq_o, 0);

      // random sweep, R2 R3 R4 R5 R7
      for (int k = 0; k < 40; k++) begin
         int r, f, len, dens;
         r = $urandom % 20;
         f = $urandom % 20;
         len = 1 + $urandom % 60;
         dens = 30 + $urandom % 71;
         setup(r, f, $urandom % 2, 1, $urandom % 2, $urandom % 2);
         for (int i = 0; i < len; i++) step(($urandom % 100) < dens, "R4 R5 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule